// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Execute Unit

This execute block handles a signed multiply-accumulate that works on 16-bit halves of its operands. It accepts a 32-bit instruction word and a flag naming which of two encodings the word uses. From the word it pulls out the register indices and two half-select bits. The indices go straight back out to the register file, and the operand values read there come back in during the same cycle.

The block picks one signed halfword from each of the two multiplicand operands and forms their signed product. It adds the 32-bit accumulate operand to that product. The wrapped sum appears one clock later, together with the destination index.

Signed overflow on the addition sets a sticky overflow flag; the result is not saturated. Only an explicit clear input takes the flag back down. A word whose fixed opcode bits do not fit the selected encoding raises a decode-error pulse in place of a result. The 4-bit condition field of the second encoding is passed out for a condition check done elsewhere.

Top module: `halfmac_unit`

## Requirements
- R1: With `fmt_sel`=0, a word is accepted only when bits [31:20] equal 0xFB1 and bits [7:6] equal 00. The fields are: first-source index in [19:16], accumulate index in [15:12], destination index in [11:8], second-source index in [3:0], first half-select in bit 5 and second half-select in bit 4.
- R2: With `fmt_sel`=1, a word is accepted only when bits [27:20] equal 0x10, bit 7 is 1 and bit 4 is 0. The fields are: destination in [19:16], accumulate in [15:12], second-source in [11:8], first-source in [3:0], second half-select in bit 6 and first half-select in bit 5.
- R3: Each half-select bit picks its operand's multiplicand independently: 1 selects bits [31:16] and 0 selects bits [15:0], read as signed 16-bit. The other half has no effect on the result.
- R4: `result` is the low 32 bits of the signed product plus `acc`, and `dst_idx` is the decoded destination index.
- R5: When the addition overflows as a signed 32-bit operation, `q_flag` is set. This means both addends share a sign and the sum's sign differs from it.
- R6: `q_flag` is sticky. It stays 1 until `q_clr` is sampled high. If a clear and a new overflow land on the same edge, the flag ends up 1.
- R7: An offered word that fails the fixed-bit check gives `dec_err`=1 and `out_valid`=0 and leaves `q_flag` unchanged. `out_valid` and `dec_err` are never high together.
- R8: `cond` shows bits [31:28] of an accepted second-encoding word, and 4'b1110 for an accepted first-encoding word.
- R9: Both halves equal to -32768 give a product of +2^30 with no overflow indication of its own.
- R10: `out_valid`, `dec_err`, `result`, `dst_idx`, `cond` and `q_flag` are registered and reflect the inputs of the previous rising edge. The three source-index outputs are combinational from `instr` and `fmt_sel`.
- R11: While `rst_n` is low, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| fmt_sel | input | 1 | 0: first encoding, 1: second encoding |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Value of the first-source register |
| opb | input | 32 | Value of the second-source register |
| acc | input | 32 | Value of the accumulate register |
| q_clr | input | 1 | Clears the sticky overflow flag |
| rn_idx | output | 4 | First-source register index |
| rm_idx | output | 4 | Second-source register index |
| ra_idx | output | 4 | Accumulate register index |
| out_valid | output | 1 | Result is valid |
| dec_err | output | 1 | Offered word failed decode |
| dst_idx | output | 4 | Destination register index |
| result | output | 32 | Wrapped accumulate sum |
| cond | output | 4 | Condition field for an external check |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The source indices are combinational, so they are checked one nanosecond after the inputs change, while the clock is still low. Every registered result falls due on the first rising edge after its inputs are applied. The bench drives inputs on a falling edge and compares the registered outputs on the next falling edge, which is half a period after that rising edge. Each check therefore sees exactly one instruction's effect. The expected overflow-flag value is carried forward from one step to the next, so a clear, a set and a step that leaves the flag alone are each compared on the cycle the flag is due to change or hold.

// File: rtl/halfmac_unit.sv
module halfmac_unit #(
  parameter int          XLEN        = 32,
  parameter int          HLEN        = 16,
  parameter int          RIDX        = 4,
  parameter logic [11:0] F1_OPC      = 12'hFB1,
  parameter logic [7:0]  F2_OPC      = 8'h10,
  parameter logic [3:0]  COND_ALWAYS = 4'b1110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            fmt_sel,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] acc,
  input  logic            q_clr,
  output logic [RIDX-1:0] rn_idx,
  output logic [RIDX-1:0] rm_idx,
  output logic [RIDX-1:0] ra_idx,
  output logic            out_valid,
  output logic            dec_err,
  output logic [RIDX-1:0] dst_idx,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cond,
  output logic            q_flag
);

  localparam int PW = 2 * HLEN;

  logic            f1_hit, f2_hit, hit, sel_a, sel_b, ovf;
  logic [RIDX-1:0] dst_d;
  logic [HLEN-1:0] half_a, half_b;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] prod_x, sum;

  assign f1_hit = (instr[31:20] == F1_OPC) && (instr[7:6] == 2'b00);
  assign f2_hit = (instr[27:20] == F2_OPC) && instr[7] && !instr[4];
  assign hit    = fmt_sel ? f2_hit : f1_hit;

  assign rn_idx = fmt_sel ? instr[3:0]   : instr[19:16];
  assign rm_idx = fmt_sel ? instr[11:8]  : instr[3:0];
  assign ra_idx = instr[15:12];
  assign dst_d  = fmt_sel ? instr[19:16] : instr[11:8];

  assign sel_a  = instr[5];
  assign sel_b  = fmt_sel ? instr[6] : instr[4];

  assign half_a = sel_a ? opa[2*HLEN-1:HLEN] : opa[HLEN-1:0];
  assign half_b = sel_b ? opb[2*HLEN-1:HLEN] : opb[HLEN-1:0];

  assign prod   = PW'($signed(half_a) * $signed(half_b));
  assign prod_x = XLEN'($signed(prod));
  assign sum    = prod_x + acc;
  assign ovf    = (prod_x[XLEN-1] == acc[XLEN-1]) && (sum[XLEN-1] != prod_x[XLEN-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_err   <= 1'b0;
      dst_idx   <= '0;
      result    <= '0;
      cond      <= '0;
      q_flag    <= 1'b0;
    end else begin
      out_valid <= in_valid && hit;
      dec_err   <= in_valid && !hit;
      if (in_valid && hit) begin
        dst_idx <= dst_d;
        result  <= sum;
        cond    <= fmt_sel ? instr[31:28] : COND_ALWAYS;
      end
      q_flag <= (q_flag && !q_clr) || (in_valid && hit && ovf);
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && dec_err));

  p_q_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clr) |=> q_flag);

  p_q_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_flag) |-> $past(in_valid));

  p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> $past(in_valid));

  p_err_holds_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit && !q_clr) |=> (q_flag == $past(q_flag)));

endmodule

// File: tb/sim_halfmac_unit.sv
`timescale 1ns/1ps
module sim_halfmac_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 0, fmt_sel = 0, q_clr = 0;
  logic [31:0] instr = 0, opa = 0, opb = 0, acc = 0;
  logic [3:0]  rn_idx, rm_idx, ra_idx, dst_idx, cond;
  logic [31:0] result;
  logic        out_valid, dec_err, q_flag;

  int tests = 0, fails = 0;
  logic qm = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  halfmac_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .instr(instr), .opa(opa), .opb(opb), .acc(acc), .q_clr(q_clr),
    .rn_idx(rn_idx), .rm_idx(rm_idx), .ra_idx(ra_idx), .out_valid(out_valid),
    .dec_err(dec_err), .dst_idx(dst_idx), .result(result), .cond(cond), .q_flag(q_flag));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(bit f, bit n, bit m, logic [3:0] d, logic [3:0] s1,
                                      logic [3:0] s2, logic [3:0] a, logic [3:0] c);
    if (!f) return {12'hFB1, s1, a, d, 2'b00, n, m, s2};
    return {c, 8'h10, d, a, s2, 1'b1, m, n, 1'b0, s1};
  endfunction

  function automatic bit ok_ref(bit f, logic [31:0] w);
    if (!f) return (w[31:20] == 12'hFB1) && (w[7:6] == 2'b00);
    return (w[27:20] == 8'h10) && w[7] && !w[4];
  endfunction

  function automatic logic [32:0] mac_ref(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                          bit n, bit m);
    longint x, y, s;
    x = n ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
    y = m ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    s = x * y + longint'($signed(c));
    return {(s > 64'sd2147483647) || (s < -64'sd2147483648), s[31:0]};
  endfunction

  task automatic step(bit v, bit f, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                      logic [31:0] c, bit clr, string tag);
    bit ok, n, m;
    logic [32:0] r;
    logic [3:0] e_dst, e_cond;
    in_valid = v; fmt_sel = f; instr = w; opa = a; opb = b; acc = c; q_clr = clr;
    ok = ok_ref(f, w);
    n  = w[5];
    m  = f ? w[6] : w[4];
    r  = mac_ref(a, b, c, n, m);
    e_dst  = f ? w[19:16] : w[11:8];
    e_cond = f ? w[31:28] : 4'b1110;
    #1;
    chk({tag, " R1/R2 rn"}, 32'(rn_idx), 32'(f ? w[3:0] : w[19:16]));
    chk({tag, " R1/R2 rm"}, 32'(rm_idx), 32'(f ? w[11:8] : w[3:0]));
    chk({tag, " R10 ra"}, 32'(ra_idx), 32'(w[15:12]));
    qm = (qm && !clr) || (v && ok && r[32]);
    @(negedge clk);
    chk({tag, " R10 out_valid"}, 32'(out_valid), 32'(v && ok));
    chk({tag, " R7 dec_err"}, 32'(dec_err), 32'(v && !ok));
    chk({tag, " R5 R6 q_flag"}, 32'(q_flag), 32'(qm));
    if (v && ok) begin
      chk({tag, " R3 R4 result"}, result, r[31:0]);
      chk({tag, " R4 dst"}, 32'(dst_idx), 32'(e_dst));
      chk({tag, " R8 cond"}, 32'(cond), 32'(e_cond));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 dec_err", 32'(dec_err), 0);
    chk("R11 q_flag", 32'(q_flag), 0);
    chk("R11 result", result, 0);
    rst_n = 1'b1;

    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 4; k++)
        step(1, f[0], enc(f[0], k[1], k[0], 4'd3, 4'd5, 4'd9, 4'd12, 4'd2),
             32'h7FFE_0003, 32'hFFFD_0100, 32'h0000_1000, 0, "R3 variant");
    step(1, 0, enc(0, 1, 1, 4'd1, 4'd2, 4'd3, 4'd4, 0), 32'h8000_1234, 32'h8000_5678, 0, 0, "R9 tt");
    chk("R9 result 2^30", result, 32'h4000_0000);
    chk("R9 no flag", 32'(q_flag), 0);
    step(1, 1, enc(1, 1, 1, 4'd7, 4'd2, 4'd3, 4'd4, 4'd0), 32'h8000_0000, 32'h8000_0000,
         32'h4000_0000, 0, "R5 pos ovf");
    chk("R5 flag set", 32'(q_flag), 1);
    chk("R5 wrapped", result, 32'h8000_0000);
    step(1, 0, enc(0, 0, 0, 4'd1, 4'd2, 4'd3, 4'd4, 0), 1, 1, 1, 0, "R6 hold");
    chk("R6 still set", 32'(q_flag), 1);
    step(0, 0, 0, 0, 0, 0, 1, "R6 clear");
    chk("R6 cleared", 32'(q_flag), 0);
    step(1, 1, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 0, "R7 bad word");
    chk("R7 no flag", 32'(q_flag), 0);
    step(1, 0, enc(0, 1, 0, 4'd1, 4'd2, 4'd3, 4'd4, 0) | 32'h40, 32'h8000_0000, 32'h0000_7FFF,
         32'h8000_0000, 0, "R1 bad bit6");
    step(1, 0, enc(0, 1, 0, 4'd1, 4'd2, 4'd3, 4'd4, 0), 32'h8000_0000, 32'h0000_7FFF,
         32'h8000_0000, 1, "R6 clr+set");
    chk("R6 set wins", 32'(q_flag), 1);
    step(1, 1, enc(1, 0, 1, 4'd15, 4'd0, 4'd8, 4'd6, 4'hB), 32'h1111_2222, 32'h3333_4444,
         32'hDEAD_BEEF, 1, "R8 cond");
    chk("R8 cond field", 32'(cond), 32'hB);

    for (int i = 0; i < 400; i++) begin
      bit f, v, c;
      logic [31:0] w, a, b, x;
      f = 1'($urandom % 2);
      v = ($urandom % 8) != 0;
      c = ($urandom % 10) == 0;
      w = enc(f, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
              4'($urandom), 4'($urandom));
      if ($urandom % 6 == 0) w = w ^ (32'd1 << ($urandom % 32));
      a = $urandom; b = $urandom; x = $urandom;
      if ($urandom % 4 == 0) x = {1'b1, 31'($urandom % 1000)};
      step(v, f, w, a, b, x, c, "rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule